// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Domain Fill Levels

This block buffers data words between a producer and a consumer that run on unrelated clocks. The producer pushes a word on each write-clock cycle with its write enable high. The consumer sees the oldest stored word at its data output and removes it on each read-clock cycle with its read enable high. Each side also has a fill-level count in its own clock domain, so either side can plan bursts without waiting for a full or empty event.

Each side keeps its own pointer as a binary counter and as a registered Gray code. Only the Gray register crosses into the other domain. It goes straight into a chain of synchronizer flops there, with no logic in between, and is then decoded back to binary. Each domain subtracts the decoded remote pointer from its own, modulo twice the depth, to get its level. The remote pointer is always a few cycles old. The write level therefore never under-reports occupancy and the read level never over-reports it, so the full and empty indications taken from these levels are safe but conservative.

Top module: `dual_clk_level_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with no loss and no duplicates. The read data output always shows the oldest stored word.
- R2: `wr_level_o` equals the number of accepted writes minus the number of reads seen through the synchronizer, modulo 512. It rises in the write-clock cycle that follows each accepted write.
- R3: `wr_full_o` is high exactly when `wr_level_o` equals 256 (the depth). A write attempted while it is high changes neither storage nor the write pointer.
- R4: `rd_empty_o` is high exactly when `rd_level_o` is 0. A read attempted while it is high does not advance the read pointer.
- R5: After writes stop, `rd_level_o` reaches the true occupancy within a few read-clock cycles. This delay comes from the Gray register plus two synchronizer flops.
- R6: Each registered Gray pointer changes at most one bit per clock of its own domain.
- R7: Neither level ever exceeds 256.
- R8: While reset is asserted, and right after it is released, both levels are 0, `rd_empty_o` is high and `wr_full_o` is low. Each domain resets its pointers and synchronizers under its own active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| wr_rst_ni | input | 1 | Write-side asynchronous reset, active low |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | 16 | Word to store |
| wr_level_o | output | 9 | Occupancy as seen in the write domain |
| wr_full_o | output | 1 | Write level has reached the depth |
| rd_clk_i | input | 1 | Read-side clock |
| rd_rst_ni | input | 1 | Read-side asynchronous reset, active low |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | 16 | Oldest stored word |
| rd_level_o | output | 9 | Occupancy as seen in the read domain |
| rd_empty_o | output | 1 | Read level is zero |

## Verification
On every cycle, the embedded properties check the single-bit Gray step, the level bound, and that a pointer holds still when a full or empty condition blocks its request. Ordering and integrity of the data, the exact number of words accepted around the full boundary, and the settling of the remote level after a burst can only be shown by the bench scenarios. Those scenarios are: isolated bursts, filling past capacity, reading from an empty buffer, and randomly interleaved traffic on both clocks, all checked against a queue of expected words.

// File: rtl/fifo_cdc_pkg.sv
package fifo_cdc_pkg;
  typedef enum logic {SIDE_WR = 1'b0, SIDE_RD = 1'b1} fifo_side_e;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              wr_clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_ptr.sv
module fifo_ptr
  import fifo_cdc_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter fifo_side_e SIDE   = SIDE_WR,
  localparam int        PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PTR_W-1:0]  peer_gray_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  gray_o,
  output logic [PTR_W-1:0]  level_o,
  output logic              step_o
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PTR_W-1:0] to_bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] bin_q, bin_d, gray_q, peer_bin;
  logic             blocked;

  assign peer_bin = to_bin(peer_gray_i);

  if (SIDE == SIDE_WR) begin : g_wr
    assign level_o = bin_q - peer_bin;
    assign blocked = (level_o == PTR_W'(DEPTH));
  end else begin : g_rd
    assign level_o = peer_bin - bin_q;
    assign blocked = (level_o == '0);
  end

  assign step_o = en_i && !blocked;
  assign bin_d  = bin_q + PTR_W'(step_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
    end
  end

  assign addr_o = bin_q[ADDR_W-1:0];
  assign gray_o = gray_q;

  // R6: one Gray bit at most per cycle
  p_gray_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(gray_q ^ $past(gray_q)) <= 1);

  // R7: level bounded by depth
  p_level_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= PTR_W'(DEPTH));

  if (SIDE == SIDE_WR) begin : g_wr_chk
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && level_o == PTR_W'(DEPTH)) |=> $stable(bin_q));
  end else begin : g_rd_chk
    p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && level_o == '0) |=> $stable(bin_q));
  end
endmodule

// File: rtl/dual_clk_level_fifo.sv
module dual_clk_level_fifo
  import fifo_cdc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              wr_clk_i,
  input  logic              wr_rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PTR_W-1:0]  wr_level_o,
  output logic              wr_full_o,
  input  logic              rd_clk_i,
  input  logic              rd_rst_ni,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PTR_W-1:0]  rd_level_o,
  output logic              rd_empty_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_in_rd, rd_gray_in_wr;
  logic              wr_step, rd_step;

  fifo_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_WR)) u_wr_ptr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .en_i(wr_en_i),
    .peer_gray_i(rd_gray_in_wr), .addr_o(wr_addr), .gray_o(wr_gray),
    .level_o(wr_level_o), .step_o(wr_step)
  );

  fifo_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_RD)) u_rd_ptr (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .en_i(rd_en_i),
    .peer_gray_i(wr_gray_in_rd), .addr_o(rd_addr), .gray_o(rd_gray),
    .level_o(rd_level_o), .step_o(rd_step)
  );

  // Gray registers feed the first sampling flop directly
  gray_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .async_i(wr_gray), .sync_o(wr_gray_in_rd)
  );

  gray_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .async_i(rd_gray), .sync_o(rd_gray_in_wr)
  );

  fifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .wr_clk_i(wr_clk_i), .we_i(wr_step), .waddr_i(wr_addr), .wdata_i(wr_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data_o)
  );

  assign wr_full_o  = (wr_level_o == PTR_W'(DEPTH));
  assign rd_empty_o = (rd_level_o == '0);

  // R8: quiet outputs straight after reset
  p_rst_state_r8: assert property (@(posedge rd_clk_i)
    $rose(rd_rst_ni) |-> rd_empty_o);

  // R4: no pop reaches storage while empty
  p_pop_gate_r4: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    rd_empty_o |-> !rd_step);
endmodule

// File: tb/tb_dual_clk_level_fifo.sv
module tb_dual_clk_level_fifo;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [8:0]  wr_level, rd_level;
  logic        wr_full, rd_empty;

  int          vecs = 0, errs = 0, popped = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q [$];

  always #4   wr_clk = ~wr_clk;   // 125 MHz
  always #5.5 rd_clk = ~rd_clk;

  dual_clk_level_fifo dut (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_level_o(wr_level), .wr_full_o(wr_full),
    .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_level_o(rd_level), .rd_empty_o(rd_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    if (!wr_full) exp_q.push_back(d);
  endtask

  task automatic wr_quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic rd_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  task automatic drain();
    @(negedge rd_clk);
    rd_en = 1'b1;
    while (exp_q.size() > 0) @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  // Monitor: scoreboard for R1
  initial begin
    forever begin
      @(negedge rd_clk);
      #1;
      if (rd_en && !rd_empty) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 extra word", int'(rd_data), -1);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R1 order", int'(rd_data), int'(e));
          popped++;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #3;
    chk(wr_level == 0, "R8 wr_level in reset", int'(wr_level), 0);
    chk(rd_empty == 1'b1, "R8 empty in reset", int'(rd_empty), 1);
    wr_quiet(4);
    wr_rst_n = 1'b1;
    rd_wait(1);
    rd_rst_n = 1'b1;
    rd_wait(2);
    chk(rd_level == 0 && rd_empty, "R8 rd after reset", int'(rd_level), 0);
    chk(wr_level == 0 && !wr_full, "R8 wr after reset", int'(wr_level), 0);

    // Short burst, reader idle
    for (int i = 0; i < 10; i++) push(16'h1000 + 16'(i));
    wr_quiet(1);
    #1;
    chk(wr_level == 10, "R2 wr_level after burst", int'(wr_level), 10);
    rd_wait(8);
    chk(rd_level == 10, "R5 rd_level settles", int'(rd_level), 10);
    drain();
    rd_wait(6);
    chk(rd_level == 0 && rd_empty, "R4 empty after drain", int'(rd_level), 0);
    wr_quiet(8);
    chk(wr_level == 0, "R2 wr_level sees reads", int'(wr_level), 0);

    // Pops on empty must be ignored
    @(negedge rd_clk);
    rd_en = 1'b1;
    rd_wait(6);
    rd_en = 1'b0;
    push(16'hBEEF);
    wr_quiet(1);
    rd_wait(8);
    chk(rd_level == 1, "R4 pointer held on empty", int'(rd_level), 1);
    drain();
    chk(popped == 11, "R1 word count", popped, 11);

    // Overfill past capacity
    for (int i = 0; i < 300; i++) push(16'h2000 + 16'(i));
    wr_quiet(1);
    #1;
    chk(wr_level == 256, "R3 wr_level at depth", int'(wr_level), 256);
    chk(wr_full == 1'b1, "R3 full flag", int'(wr_full), 1);
    chk(exp_q.size() == 256, "R3 accepted count", exp_q.size(), 256);
    rd_wait(8);
    chk(rd_level == 256, "R7 rd_level capped", int'(rd_level), 256);
    drain();
    chk(popped == 267, "R3 no extra stored", popped, 267);
    rd_wait(4);
    chk(rd_empty == 1'b1, "R4 empty after full drain", int'(rd_empty), 1);

    // Interleaved traffic
    fork
      begin
        for (int i = 0; i < 600; i++) begin
          if ($urandom_range(0, 3) == 0) wr_quiet(1);
          else push(16'h4000 + 16'(i));
        end
        wr_quiet(1);
      end
      begin
        for (int i = 0; i < 700; i++) begin
          @(negedge rd_clk);
          rd_en = ($urandom_range(0, 2) != 0);
        end
        rd_en = 1'b0;
      end
    join
    drain();
    rd_wait(6);
    wr_quiet(8);
    chk(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);
    chk(rd_level == 0 && rd_empty, "R4 final empty", int'(rd_level), 0);
    chk(wr_level == 0 && !wr_full, "R2 final wr_level", int'(wr_level), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule